// File: doc/BRIEF.md
# Flash Word Program Controller

This block writes a run of consecutive words into a parallel NOR-style flash device, acting as the bus master. A start pulse supplies the first and last word addresses. For each address the controller fetches the word from a data source port. It then issues the four-write program command sequence, polls the target location until the device finishes its internal program, and reads the word back to confirm it.

A clean read-back advances the address, and a clean read-back of the last address ends the run with a one-cycle done pulse. If the device never reports completion within a bounded number of polls, the run stops. A read-back mismatch also stops the run. In both cases the error output is raised and the failing address is held for the host.

The flash bus uses single-cycle strobes. A write is one cycle with the write strobe high. A read is one cycle with the read strobe high, and the device returns the data on the read-data port in the following cycle.

Top module: `fpc_ctrl`

## Requirements
- R1: After reset, busy, done and error are low, and neither the write strobe nor the read strobe is asserted while busy is low.
- R2: For each word, the controller writes four bus cycles in this order: 0x00AA to address 0x555, 0x0055 to address 0x2AA, 0x00A0 to address 0x555, then the word to its target address.
- R3: After the fourth write, the controller reads the target address every second cycle. Polling ends when read-data bit 7 equals bit 7 of the written word. No write occurs while polling.
- R4: After polling ends, the controller issues exactly one further read of the target address and compares all data bits with the written word.
- R5: Words are programmed at addresses first, first+1, up to last, each exactly once. Each word's data is the value on word_data while word_addr shows that address, and first equal to last programs a single word.
- R6: A passing read-back of the last address is followed by done high for exactly one cycle, with busy and error low in that cycle.
- R7: If POLL_LIMIT poll reads of one word all miss, the run stops with error high, busy low, no done pulse, and err_addr set to that word's address.
- R8: A read-back mismatch stops the run with error high, busy low, no done pulse, and err_addr set to that address. No later address is written.
- R9: Start is accepted only when the block is idle. Busy is high in the cycle after an accepted start. A start while busy changes neither the addresses nor the bus traffic.
- R10: The write strobe and the read strobe are never high in the same cycle.
- R11: An accepted start clears a held error, and the new run proceeds normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Run request pulse |
| first_addr | input | AW | First word address of the run |
| last_addr | input | AW | Last word address of the run (not below first_addr) |
| word_addr | output | AW | Address whose data is wanted on word_data |
| word_data | input | DW | Source data for word_addr |
| fl_addr | output | AW | Flash bus address |
| fl_wdata | output | DW | Flash bus write data |
| fl_wr | output | 1 | Flash write strobe, one cycle per write |
| fl_rd | output | 1 | Flash read strobe, one cycle per read |
| fl_rdata | input | DW | Flash read data, valid the cycle after fl_rd |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run completes |
| error | output | 1 | Held high after a failed run until the next start |
| err_addr | output | AW | Address of the word that failed |

## Verification
A bus write is due in the cycle after the edge that entered the command state, so the bench compares each fl_wr cycle, sampled on the falling edge, with the head of an expected-write queue built from R2 and R5. Read data is due one cycle after fl_rd, and the bench's device model answers with a register updated on that edge. Because a poll-and-check pair takes two cycles, a device latency of L cycles gives ceil(L/2)+1 poll reads per word; the bench checks that read count exactly. Busy is due one cycle after start. Done and error are due in the first cycle in which busy is low, and the bench samples both there and again one cycle later.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CMD,
    ST_PRD,
    ST_PCHK,
    ST_VRD,
    ST_VCHK,
    ST_DONE
  } fpc_state_e;

  localparam int SEQ_LEN = 4;

  localparam logic [11:0] UNLK_ADDR_A = 12'h555;
  localparam logic [11:0] UNLK_ADDR_B = 12'h2AA;
  localparam logic [7:0]  UNLK_KEY_A  = 8'hAA;
  localparam logic [7:0]  UNLK_KEY_B  = 8'h55;
  localparam logic [7:0]  PGM_OPCODE  = 8'hA0;

  // address of a command step (step 3 is the target write, handled elsewhere)
  function automatic logic [11:0] seq_cmd_addr(input logic [1:0] step);
    return (step == 2'd1) ? UNLK_ADDR_B : UNLK_ADDR_A;
  endfunction

  // data byte of a command step
  function automatic logic [7:0] seq_cmd_code(input logic [1:0] step);
    case (step)
      2'd0:    return UNLK_KEY_A;
      2'd1:    return UNLK_KEY_B;
      default: return PGM_OPCODE;
    endcase
  endfunction

  // status poll: device reports completion once the polled bit equals the written bit
  function automatic logic poll_bit_match(input logic rd_bit, input logic wr_bit);
    return rd_bit == wr_bit;
  endfunction

endpackage

// File: rtl/fpc_cmd_seq.sv
module fpc_cmd_seq #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic [1:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_data,
  output logic          last_step
);
  import fpc_pkg::*;

  localparam logic [1:0] LAST_IDX = 2'(SEQ_LEN - 1);

  assign last_step = (step == LAST_IDX);

  always_comb begin
    if (last_step) begin
      bus_addr = tgt_addr;
      bus_data = tgt_data;
    end else begin
      bus_addr = AW'(seq_cmd_addr(step));
      bus_data = DW'(seq_cmd_code(step));
    end
  end

endmodule

// File: rtl/fpc_addr_walker.sv
module fpc_addr_walker #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          adv,
  input  logic [AW-1:0] first_in,
  input  logic [AW-1:0] last_in,
  output logic [AW-1:0] cur,
  output logic          at_last
);
  logic [AW-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur    <= '0;
      last_q <= '0;
    end else if (load) begin
      cur    <= first_in;
      last_q <= last_in;
    end else if (adv) begin
      cur    <= cur + AW'(1);
    end
  end

  assign at_last = (cur == last_q);

endmodule

// File: rtl/fpc_poll_timer.sv
module fpc_poll_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (tick) cnt <= cnt + CW'(1);
  end

  // true while the miss now being judged is the LIMIT-th
  assign expired = (cnt == LAST_CNT);

endmodule

// File: rtl/fpc_ctrl.sv
module fpc_ctrl #(
  parameter int AW         = 12,
  parameter int DW         = 16,
  parameter int POLL_LIMIT = 16,
  parameter int POLL_BIT   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] first_addr,
  input  logic [AW-1:0] last_addr,
  output logic [AW-1:0] word_addr,
  input  logic [DW-1:0] word_data,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_wr,
  output logic          fl_rd,
  input  logic [DW-1:0] fl_rdata,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [AW-1:0] err_addr
);
  import fpc_pkg::*;

  fpc_state_e    state;
  logic [1:0]    step;
  logic [DW-1:0] wdata_q;
  logic          err_q;
  logic [AW-1:0] err_addr_q;

  // named events, also observed by the checker
  logic          start_take;
  logic          wk_load;
  logic          wk_adv;
  logic          poll_hit;
  logic          poll_miss;
  logic          poll_expire;
  logic          verify_ok;
  logic          verify_bad;
  logic          fail_evt;
  logic          cmd_first;
  logic          cmd_last;
  logic          at_last;
  logic [AW-1:0] cur;
  logic [AW-1:0] seq_addr;
  logic [DW-1:0] seq_data;

  fpc_addr_walker #(.AW(AW)) u_walk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wk_load),
    .adv      (wk_adv),
    .first_in (first_addr),
    .last_in  (last_addr),
    .cur      (cur),
    .at_last  (at_last)
  );

  fpc_poll_timer #(.LIMIT(POLL_LIMIT)) u_ptmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state == ST_LOAD),
    .tick    (poll_miss),
    .expired (poll_expire)
  );

  fpc_cmd_seq #(.AW(AW), .DW(DW)) u_seq (
    .step      (step),
    .tgt_addr  (cur),
    .tgt_data  (wdata_q),
    .bus_addr  (seq_addr),
    .bus_data  (seq_data),
    .last_step (cmd_last)
  );

  assign start_take = start && (state == ST_IDLE);
  assign wk_load    = start_take;
  assign cmd_first  = (state == ST_CMD) && (step == 2'd0);

  assign poll_hit   = (state == ST_PCHK) &&
                      poll_bit_match(fl_rdata[POLL_BIT], wdata_q[POLL_BIT]);
  assign poll_miss  = (state == ST_PCHK) && !poll_hit;
  assign verify_ok  = (state == ST_VCHK) && (fl_rdata == wdata_q);
  assign verify_bad = (state == ST_VCHK) && (fl_rdata != wdata_q);
  assign wk_adv     = verify_ok && !at_last;
  assign fail_evt   = verify_bad || (poll_miss && poll_expire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      step    <= '0;
      wdata_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_take) state <= ST_LOAD;
        ST_LOAD: begin
          wdata_q <= word_data;
          step    <= '0;
          state   <= ST_CMD;
        end
        ST_CMD: begin
          if (cmd_last) state <= ST_PRD;
          else          step  <= step + 2'd1;
        end
        ST_PRD:  state <= ST_PCHK;
        ST_PCHK: begin
          if (poll_hit)       state <= ST_VRD;
          else if (fail_evt)  state <= ST_IDLE;
          else                state <= ST_PRD;
        end
        ST_VRD:  state <= ST_VCHK;
        ST_VCHK: begin
          if (verify_bad)     state <= ST_IDLE;
          else if (at_last)   state <= ST_DONE;
          else                state <= ST_LOAD;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q      <= 1'b0;
      err_addr_q <= '0;
    end else if (start_take) begin
      err_q      <= 1'b0;
    end else if (fail_evt) begin
      err_q      <= 1'b1;
      err_addr_q <= cur;
    end
  end

  assign fl_wr    = (state == ST_CMD);
  assign fl_rd    = (state == ST_PRD) || (state == ST_VRD);
  assign fl_addr  = fl_wr ? seq_addr : cur;
  assign fl_wdata = fl_wr ? seq_data : '0;

  assign word_addr = cur;
  assign busy      = (state != ST_IDLE) && (state != ST_DONE);
  assign done      = (state == ST_DONE);
  assign error     = err_q;
  assign err_addr  = err_addr_q;

endmodule

// File: rtl/fpc_ctrl_chk.sv
module fpc_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          fl_wr,
  input logic          fl_rd,
  input logic [DW-1:0] fl_wdata,
  input logic          wk_load,
  input logic          cmd_first,
  input logic          poll_expire,
  input logic          poll_miss,
  input logic          fail_evt
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!fl_wr && !fl_rd));

  p_unlock_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_first |=> (fl_wr && fl_wdata == DW'(8'h55)));

  p_poll_after_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fl_wr) |-> fl_rd);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!error && !busy));

  p_timeout_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_miss && poll_expire) |=> (error && !busy));

  p_fail_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> (error && !busy && !done));

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !wk_load);

  p_strobe_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_wr && fl_rd));

endmodule

bind fpc_ctrl fpc_ctrl_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .error       (error),
  .fl_wr       (fl_wr),
  .fl_rd       (fl_rd),
  .fl_wdata    (fl_wdata),
  .wk_load     (wk_load),
  .cmd_first   (cmd_first),
  .poll_expire (poll_expire),
  .poll_miss   (poll_miss),
  .fail_evt    (fail_evt)
);

// File: tb/sim_fpc_ctrl.sv
module sim_fpc_ctrl;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int PL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] first_addr = '0;
  logic [AW-1:0] last_addr = '0;
  logic [AW-1:0] word_addr;
  logic [DW-1:0] word_data;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic          fl_wr;
  logic          fl_rd;
  logic [DW-1:0] fl_rdata = '0;
  logic          busy;
  logic          done;
  logic          error;
  logic [AW-1:0] err_addr;

  always #10 clk = ~clk;

  fpc_ctrl #(.AW(AW), .DW(DW), .POLL_LIMIT(PL), .POLL_BIT(7)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_addr(first_addr), .last_addr(last_addr),
    .word_addr(word_addr), .word_data(word_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_wr(fl_wr), .fl_rd(fl_rd),
    .fl_rdata(fl_rdata), .busy(busy), .done(done), .error(error),
    .err_addr(err_addr)
  );

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return (DW'(a) * 16'h9E37) ^ 16'h5A5A;
  endfunction

  assign word_data = pat(word_addr);

  int tests = 0;
  int failed = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural flash device ----------------
  logic [DW-1:0] mem [int];
  int            dev_lat = 0;
  int            stuck_a = -1;
  int            corrupt_a = -1;
  int            busy_left = 0;
  int            ul = 0;
  int            prog_a = 0;
  logic [DW-1:0] prog_d = '0;

  always @(posedge clk) begin
    if (fl_rd) begin
      if (busy_left > 0 && int'(fl_addr) == prog_a) fl_rdata <= ~prog_d;
      else if (mem.exists(int'(fl_addr)))           fl_rdata <= mem[int'(fl_addr)];
      else                                          fl_rdata <= '1;
    end
    if (fl_wr) begin
      if (ul == 3) begin
        prog_a = int'(fl_addr);
        prog_d = fl_wdata;
        mem[prog_a] = (prog_a == corrupt_a) ? (fl_wdata ^ 16'h0001) : fl_wdata;
        busy_left = (prog_a == stuck_a) ? 32'h4000_0000 : dev_lat;
        ul = 0;
      end else begin
        ul = ul + 1;
      end
    end else if (busy_left > 0) begin
      busy_left = busy_left - 1;
    end
  end

  // ---------------- reference trace, compared every clock ----------------
  typedef struct {
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    bit            tgt;
  } wr_t;

  wr_t exp_q[$];
  int  cur_tgt = -1;
  int  rd_total = 0;
  int  rd_stuck = 0;
  int  done_cnt = 0;
  bit  prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (fl_wr) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2/R5 unexpected write", 32'(fl_addr), 32'hFFFF_FFFF);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          chk(fl_addr == e.a, "R2/R5 write address", 32'(fl_addr), 32'(e.a));
          chk(fl_wdata == e.d, "R2/R5 write data", 32'(fl_wdata), 32'(e.d));
          if (e.tgt) cur_tgt = int'(e.a);
        end
      end
      if (fl_rd) begin
        rd_total++;
        if (int'(fl_addr) == stuck_a) rd_stuck++;
        chk(int'(fl_addr) == cur_tgt, "R3 poll/verify address", 32'(fl_addr), 32'(cur_tgt));
      end
      if (fl_wr && fl_rd) chk(1'b0, "R10 both strobes", 32'd1, 32'd0);
      if (done) begin
        done_cnt++;
        if (prev_done) chk(1'b0, "R6 done wider than one cycle", 32'd1, 32'd0);
      end
      prev_done = done;
    end
  end

  // ---------------- one programming run ----------------
  task automatic run(input int f, input int l, input int lat, input int stk,
                     input int cor, input int bad_a, input bit poke);
    int n;
    int words;
    bit exp_err;
    exp_err   = (bad_a >= 0);
    dev_lat   = lat;
    stuck_a   = stk;
    corrupt_a = cor;
    rd_total  = 0;
    rd_stuck  = 0;
    done_cnt  = 0;
    words     = 0;
    for (int a = f; a <= l; a++) begin
      exp_q.push_back('{AW'(12'h555), DW'(16'h00AA), 1'b0});
      exp_q.push_back('{AW'(12'h2AA), DW'(16'h0055), 1'b0});
      exp_q.push_back('{AW'(12'h555), DW'(16'h00A0), 1'b0});
      exp_q.push_back('{AW'(a), pat(AW'(a)), 1'b1});
      words++;
      if (exp_err && a == bad_a) break;
    end
    @(negedge clk);
    start = 1'b1;
    first_addr = AW'(f);
    last_addr  = AW'(l);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after accepted start", 32'(busy), 32'd1);
    chk(error == 1'b0, "R11 error cleared by start", 32'(error), 32'd0);
    n = 0;
    while (busy && n < 20000) begin
      if (poke && n == 10) begin
        start = 1'b1;
        first_addr = AW'(12'h010);
        last_addr  = AW'(12'h011);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (exp_err) begin
      chk(error == 1'b1, "R7/R8 error raised", 32'(error), 32'd1);
      chk(int'(err_addr) == bad_a, "R7/R8 failing address", 32'(err_addr), 32'(bad_a));
      chk(done == 1'b0, "R7/R8 no done", 32'(done), 32'd0);
    end else begin
      chk(done == 1'b1, "R6 done when busy falls", 32'(done), 32'd1);
      chk(error == 1'b0, "R6 no error", 32'(error), 32'd0);
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", 32'(done), 32'd0);
    chk(done_cnt == (exp_err ? 0 : 1), "R6 done pulse count", 32'(done_cnt), 32'(exp_err ? 0 : 1));
    chk(exp_q.size() == 0, "R5 all expected writes seen", 32'(exp_q.size()), 32'd0);
    if (!exp_err)
      chk(rd_total == words * ((lat + 1) / 2 + 2), "R3/R4 read count",
          32'(rd_total), 32'(words * ((lat + 1) / 2 + 2)));
    if (stk >= 0)
      chk(rd_stuck == PL, "R7 polls before timeout", 32'(rd_stuck), 32'(PL));
    for (int a = f; a <= l; a++) begin
      bit should;
      should = !exp_err || a < bad_a;
      if (should)
        chk(mem.exists(a) && mem[a] == pat(AW'(a)), "R5 programmed word",
            mem.exists(a) ? 32'(mem[a]) : 32'hDEAD, 32'(pat(AW'(a))));
      else if (a > bad_a)
        chk(!mem.exists(a), "R8 no write after failure", 32'(a), 32'hFFFF_FFFF);
    end
    exp_q.delete();
    cur_tgt = -1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0,  "R1 busy in reset",  32'(busy),  32'd0);
    chk(done == 1'b0,  "R1 done in reset",  32'(done),  32'd0);
    chk(error == 1'b0, "R1 error in reset", 32'(error), 32'd0);
    chk(!fl_wr && !fl_rd, "R1 no strobes in reset", 32'({fl_wr, fl_rd}), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !fl_wr && !fl_rd, "R1 quiet after reset", 32'({busy, fl_wr, fl_rd}), 32'd0);

    run(12'h100, 12'h104, 3, -1, -1, -1, 1'b0);   // R2 R3 R4 R5 R6, busy device
    run(12'h200, 12'h200, 0, -1, -1, -1, 1'b0);   // R5 single word, instant completion
    run(12'h300, 12'h303, 6, -1, -1, -1, 1'b1);   // R9 start while busy ignored
    chk(!mem.exists(32'h010), "R9 ignored start wrote nothing", 32'h010, 32'hFFFF_FFFF);
    run(12'h400, 12'h405, 2, 12'h402, -1, 12'h402, 1'b0);  // R7 poll timeout
    run(12'h500, 12'h503, 1, -1, 12'h501, 12'h501, 1'b0);  // R8 verify mismatch
    run(12'h600, 12'h602, 1, -1, -1, -1, 1'b0);   // R11 recovery after error

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    failed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule